// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer and Vector Addresser

This block fetches the type number of an interrupt and turns it into an address in the real-mode vector table. An arbiter pulses `start_i` to begin a transaction. When `need_ack_i` is high, the block runs a two-pulse bus handshake on the active-low strobe `ack_n_o` and holds `lock_o` high across it. The first pulse only tells the external device to get ready. The type byte is read from `data_i` during the second pulse. When `need_ack_i` is low, the arbiter already knows the type and gives it on `known_type_i`, so the handshake is skipped.

With the type in hand, the block computes the byte addresses of the two words of its four-byte vector entry. The table starts at address zero. The handler offset word sits at type*4 and the segment word at type*4+2. `done_o` pulses for one clock once the type and both addresses are valid. These outputs then hold until the next transaction finishes.

The controller has six states:
- ST_IDLE waits for a start.
- ST_ACK1 is the first low pulse.
- ST_GAP is the idle spacing between pulses.
- ST_ACK2 is the second low pulse, which captures the type.
- ST_CALC registers the addresses.
- ST_DONE raises the done pulse.

Its transitions are:
- ST_IDLE to ST_ACK1 on a start that needs the handshake.
- ST_IDLE to ST_CALC on a start with a known type.
- ST_ACK1 to ST_GAP after the pulse width.
- ST_GAP to ST_ACK2 after the gap.
- ST_ACK2 to ST_CALC after the pulse width.
- ST_CALC to ST_DONE, always.
- ST_DONE to ST_IDLE, always.

Top module: `irq_ack_sequencer`

## Requirements
- R1: A start with `need_ack_i`=1 produces exactly two low pulses on `ack_n_o`, and each pulse is low for exactly 2 clocks. The first pulse is low in the 1st and 2nd cycles after the edge that accepted the start.
- R2: `ack_n_o` stays high for exactly 4 clocks between the two pulses, so the second pulse is low in the 7th and 8th cycles after the accepting edge.
- R3: The type is sampled from `data_i[7:0]` only at the clock edge that ends the last low cycle of the second pulse. `data_i` at any other time, and `known_type_i` during a handshake, have no effect on `type_o`.
- R4: `lock_o` is high from the first low cycle of the first pulse through the last low cycle of the second pulse, and low at all other times.
- R5: `off_addr_o` equals type*4, zero-extended to the address width. For example, type 41H gives 104H and type 02H gives 008H.
- R6: `seg_addr_o` equals type*4+2. For example, type 02H gives 00AH.
- R7: `done_o` is high for exactly one clock: the 10th cycle after the accepting edge on the handshake path, or the 2nd cycle on the known-type path. `type_o` and both addresses are valid in that cycle.
- R8: A start with `need_ack_i`=0 produces no pulse on `ack_n_o`, keeps `lock_o` low, and yields `type_o` equal to `known_type_i` as sampled at the accepting edge.
- R9: A start is accepted only in the idle state. A start held high during a transaction, whatever its `need_ack_i` and `known_type_i`, does not alter that transaction or begin another before `done_o`.
- R10: After reset, `ack_n_o` is 1, `lock_o` and `done_o` are 0, and `type_o`, `off_addr_o` and `seg_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request from the arbiter |
| need_ack_i | input | 1 | 1: fetch the type by handshake; 0: use known_type_i |
| known_type_i | input | 8 | Type supplied by the arbiter when no handshake is needed |
| data_i | input | 8 | Low data bus lines carrying the type during the second pulse |
| ack_n_o | output | 1 | Active-low acknowledge strobe |
| lock_o | output | 1 | Bus lock held across both pulses |
| done_o | output | 1 | One-clock pulse: type and addresses valid |
| type_o | output | 8 | Captured or supplied type number |
| off_addr_o | output | 20 | Byte address of the handler offset word |
| seg_addr_o | output | 20 | Byte address of the handler segment word |

## Verification
The hardest case to reach from the ports is the exact sampling instant inside the second pulse. A design that samples one cycle early, or during the first pulse, still returns a plausible byte. To expose this, the bench drives the bitwise complement of the type on `data_i` in every cycle except the final low cycle of the second pulse, so any misplaced sample yields the wrong type. The bench also holds `start_i` high through a whole transaction with a conflicting known type. This shows the busy controller ignores it. All 256 types are swept on both paths.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK1,
        ST_GAP,
        ST_ACK2,
        ST_CALC,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/irq_phase_timer.sv
// Counts clocks spent in the current controller state; cleared on every state change.
module irq_phase_timer #(
    parameter int CNT_MAX = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    output logic [$clog2(CNT_MAX+1)-1:0] cnt_o
);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != CNT_W'(CNT_MAX)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(CNT_MAX)); // R2
endmodule

// File: rtl/irq_vec_calc.sv
// Holds the type number and forms the two word addresses of its vector entry.
module irq_vec_calc #(
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_bus_i,
    input  logic              cap_known_i,
    input  logic [TYPE_W-1:0] bus_type_i,
    input  logic [TYPE_W-1:0] known_type_i,
    input  logic              calc_i,
    output logic [TYPE_W-1:0] type_o,
    output logic [ADDR_W-1:0] off_addr_o,
    output logic [ADDR_W-1:0] seg_addr_o
);
    localparam int ENTRY_SHIFT = 2;
    localparam int PAD_W       = ADDR_W - TYPE_W - ENTRY_SHIFT;

    logic [ADDR_W-1:0] entry_base;

    generate
        if (PAD_W > 0) begin : g_pad
            assign entry_base = {{PAD_W{1'b0}}, type_o, {ENTRY_SHIFT{1'b0}}};
        end else begin : g_nopad
            assign entry_base = ADDR_W'({type_o, {ENTRY_SHIFT{1'b0}}});
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_o <= '0;
        end else if (cap_bus_i) begin
            type_o <= bus_type_i;
        end else if (cap_known_i) begin
            type_o <= known_type_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_addr_o <= '0;
            seg_addr_o <= '0;
        end else if (calc_i) begin
            off_addr_o <= entry_base;
            seg_addr_o <= entry_base | ADDR_W'(2);
        end
    end

    AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_bus_i && cap_known_i)); // R3
    AST_SEG_ABOVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        calc_i |=> (seg_addr_o == off_addr_o + ADDR_W'(2))); // R6
    AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        calc_i |=> (off_addr_o[1:0] == 2'b00)); // R5
endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer
    import irq_ack_pkg::*;
#(
    parameter int TYPE_W     = 8,
    parameter int ADDR_W     = 20,
    parameter int PULSE_CLKS = 2,
    parameter int GAP_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              need_ack_i,
    input  logic [TYPE_W-1:0] known_type_i,
    input  logic [TYPE_W-1:0] data_i,
    output logic              ack_n_o,
    output logic              lock_o,
    output logic              done_o,
    output logic [TYPE_W-1:0] type_o,
    output logic [ADDR_W-1:0] off_addr_o,
    output logic [ADDR_W-1:0] seg_addr_o
);
    localparam int CNT_MAX = (PULSE_CLKS > GAP_CLKS) ? PULSE_CLKS : GAP_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic pulse_end, gap_end;
    logic cap_bus, cap_known, calc;

    assign pulse_end = (cnt == CNT_W'(PULSE_CLKS - 1));
    assign gap_end   = (cnt == CNT_W'(GAP_CLKS - 1));

    irq_phase_timer #(.CNT_MAX(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .cnt_o (cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = need_ack_i ? ST_ACK1 : ST_CALC;
            ST_ACK1: if (pulse_end) state_d = ST_GAP;
            ST_GAP:  if (gap_end) state_d = ST_ACK2;
            ST_ACK2: if (pulse_end) state_d = ST_CALC;
            ST_CALC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output logic
    always_comb begin
        ack_n_o   = 1'b1;
        lock_o    = 1'b0;
        done_o    = 1'b0;
        cap_bus   = 1'b0;
        cap_known = 1'b0;
        calc      = 1'b0;
        unique case (state_q)
            ST_IDLE: cap_known = start_i && !need_ack_i;
            ST_ACK1: begin
                ack_n_o = 1'b0;
                lock_o  = 1'b1;
            end
            ST_GAP:  lock_o = 1'b1;
            ST_ACK2: begin
                ack_n_o = 1'b0;
                lock_o  = 1'b1;
                cap_bus = pulse_end;
            end
            ST_CALC: calc = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    irq_vec_calc #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_vec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_bus_i    (cap_bus),
        .cap_known_i  (cap_known),
        .bus_type_i   (data_i),
        .known_type_i (known_type_i),
        .calc_i       (calc),
        .type_o       (type_o),
        .off_addr_o   (off_addr_o),
        .seg_addr_o   (seg_addr_o)
    );

    AST_ACK_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_o |-> lock_o); // R4
    AST_LOCK_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(!ack_n_o)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_CAPTURE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_bus |-> (!ack_n_o && lock_o)); // R3
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE)); // R9
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |=> !ack_n_o); // R1
endmodule

// File: tb/irq_ack_sequencer_tb.sv
module irq_ack_sequencer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        need_ack_i = 1'b0;
    logic [7:0]  known_type_i = '0;
    logic [7:0]  data_i = '0;
    logic        ack_n_o, lock_o, done_o;
    logic [7:0]  type_o;
    logic [19:0] off_addr_o, seg_addr_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ack_sequencer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .need_ack_i   (need_ack_i),
        .known_type_i (known_type_i),
        .data_i       (data_i),
        .ack_n_o      (ack_n_o),
        .lock_o       (lock_o),
        .done_o       (done_o),
        .type_o       (type_o),
        .off_addr_o   (off_addr_o),
        .seg_addr_o   (seg_addr_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One transaction; k counts negedges after the edge that accepts start.
    task automatic run_txn(input bit ack, input logic [7:0] ty, input bit hold);
        int done_k;
        bit exp_ack, exp_lock, exp_done;
        done_k = ack ? 9 : 1;
        @(negedge clk);
        start_i      = 1'b1;
        need_ack_i   = ack;
        known_type_i = ack ? ~ty : ty;
        data_i       = ~ty;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 0 && !hold) start_i = 1'b0;
            if (k == 0 && hold) begin
                need_ack_i   = 1'b0;
                known_type_i = ty ^ 8'h5A;
            end
            if (k == 8 && hold) start_i = 1'b0;
            exp_ack  = ack && (k == 0 || k == 1 || k == 6 || k == 7);
            exp_lock = ack && (k <= 7);
            exp_done = (k == done_k);
            if (ack) begin
                check(ack_n_o == !exp_ack, (k < 2) ? "R1" : "R2", ack_n_o, !exp_ack);
                check(lock_o == exp_lock, "R4", lock_o, exp_lock);
            end else begin
                check(ack_n_o == 1'b1, "R8", ack_n_o, 1);
                check(lock_o == 1'b0, "R8", lock_o, 0);
            end
            check(done_o == exp_done, hold ? "R9" : "R7", done_o, exp_done);
            if (k == done_k) begin
                check(type_o == ty, ack ? (hold ? "R9" : "R3") : "R8", type_o, ty);
                check(off_addr_o == 20'(ty) * 4, "R5", off_addr_o, 20'(ty) * 4);
                check(seg_addr_o == 20'(ty) * 4 + 2, "R6", seg_addr_o, 20'(ty) * 4 + 2);
            end
            data_i = (ack && k == 7) ? ty : ~ty;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(ack_n_o == 1'b1, "R10", ack_n_o, 1);
        check(lock_o == 1'b0, "R10", lock_o, 0);
        check(done_o == 1'b0, "R10", done_o, 0);
        check(type_o == 8'h00, "R10", type_o, 0);
        check(off_addr_o == 20'h0, "R10", off_addr_o, 0);
        check(seg_addr_o == 20'h0, "R10", seg_addr_o, 0);
        rst_n = 1'b1;
        // Known corner values: 41H -> 104H, 02H -> 008H/00AH
        run_txn(1'b1, 8'h41, 1'b0);
        check(off_addr_o == 20'h104, "R5", off_addr_o, 20'h104);
        run_txn(1'b0, 8'h02, 1'b0);
        check(off_addr_o == 20'h008, "R5", off_addr_o, 20'h008);
        check(seg_addr_o == 20'h00A, "R6", seg_addr_o, 20'h00A);
        for (int t = 0; t < 256; t++) run_txn(1'b1, 8'(t), 1'b0);
        for (int t = 0; t < 256; t++) run_txn(1'b0, 8'(t), 1'b0);
        for (int t = 0; t < 256; t += 17) run_txn(1'b1, 8'(t), 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule